// File: doc/BRIEF.md
# USB Function Event Latch and Interrupt Mask

This block gathers the single-cycle event strobes produced by a USB function channel into a sticky event register. It pairs that register with a mask register of the same layout and drives one interrupt request line. Software finds out what happened by reading the event register. It acknowledges an event by writing a one to its bit. An interrupt stays pending while any enabled event is still latched.

Three events are derived inside the block rather than arriving as ready-made strobes:

- **Idle-change event.** It comes from a synchronizer and edge detector on the line's suspend/idle level. The synchronized level can also be read back.
- **Receive-busy event.** It fires only for the first character of a run of characters that found no receive buffer.
- **Transmit-buffer-done event.** It picks its completion point from the buffer's last flag. With the flag clear, the point is the final write into the transmit FIFO. With the flag set, it is the final character leaving on the wire.

All other events (bus reset seen, four per-endpoint transmit errors, start of frame, receive buffer closed) are latched as they arrive.

The register bus is a plain address, write strobe, read strobe and data interface. Read data is registered and appears on the cycle after the read strobe.

Top module: `usb_evt_irq_ctl`

## Requirements
- R1: After reset the event register, the mask register and `irq` are all zero.
- R2: Register bits are numbered with bit 0 as the MSB of the 16-bit word (bus bit 15). The event bit positions are fixed as follows:
  - bus reset seen = 6 (bus bit 9)
  - idle change = 7 (bus bit 8)
  - transmit error on endpoints 4, 3, 2, 1 = 8, 9, 10, 11 (bus bits 7..4)
  - start of frame = 12 (bus bit 3)
  - receive busy = 13 (bus bit 2)
  - transmit buffer done = 14 (bus bit 1)
  - receive buffer done = 15 (bus bit 0)

  Bits 0–5 (bus bits 15..10) read as zero, and writes to them are ignored in both registers.
- R3: An event strobe sets its bit on the next clock edge. The bit then holds until software clears it.
- R4: A write to the event register at offset 0xA10 clears every bit written as one and leaves every bit written as zero unchanged.
- R5: When a set strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: The mask register at offset 0xA14 is read/write with the same layout as the event register.
- R7: `irq` is registered. It is high in the cycle after any event bit is set whose mask bit is one, and it stays high until all such bits are cleared. Events whose mask bit is zero never raise it.
- R8: The idle-change bit sets after a change in either direction of `line_idle`, following a two-stage synchronizer. The synchronized level reads back at offset 0xA18 in bus bit 0.
- R9: The receive-busy bit sets only on the first character with no buffer available. Further unbuffered characters do not set it again until a character is received with a buffer available.
- R10: The transmit-buffer-done bit is selected by `tx_last_flag`:
  - With the flag at 0, it sets on `tx_last_fifo` and ignores `tx_last_wire`.
  - With the flag at 1, it sets on `tx_last_wire` and ignores `tx_last_fifo`.
- R11: `bus_rdata` carries the addressed register one cycle after `bus_rd`. It reads zero for unmapped addresses and when no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| line_idle | input | 1 | Asynchronous line suspend/idle level |
| usb_rst_det | input | 1 | Bus reset detected strobe |
| tx_err_ep | input | 4 | Transmit error strobes, index k is endpoint k+1 |
| sof_rcvd | input | 1 | Start-of-frame packet received strobe |
| rx_char_valid | input | 1 | A received character is presented |
| rx_buf_avail | input | 1 | A receive buffer is available for that character |
| tx_last_fifo | input | 1 | Last character of a buffer written to the transmit FIFO |
| tx_last_wire | input | 1 | Last character of a buffer sent on the line |
| tx_last_flag | input | 1 | Last flag of the current transmit buffer |
| rx_buf_closed | input | 1 | Receive buffer filled and its descriptor closed |
| irq | output | 1 | Interrupt request |

## Verification
The case that matters most is an event strobe arriving in the same cycle as a software write that clears the same bit. The bench provokes it on purpose by pulsing start of frame while writing a one to that bit. Random stimulus also does so often, mixing clearing writes with event strobes cycle by cycle. The outcome is judged by reading the register back: the bit must still be set, and `irq` must stay high when that bit is enabled. A second overlap is a mask write landing alongside a new event. Here the bench model checks that `irq` follows the old mask in that cycle and the new mask one edge later.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    localparam int REG_W   = 16;
    localparam int NUM_EVT = 10;
    localparam int NUM_EP  = 4;

    // Field order from MSB to LSB matches the register layout of the live bits
    typedef struct packed {
        logic              usb_rst;
        logic              idle_chg;
        logic [NUM_EP-1:0] tx_err;    // [3] = endpoint 4 ... [0] = endpoint 1
        logic              sof;
        logic              busy;
        logic              tx_done;
        logic              rx_done;
    } evt_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_EVT,
        SEL_MASK,
        SEL_STAT
    } reg_sel_t;

    // Place the live event bits in the low end of a bus word, reserved bits zero
    function automatic logic [REG_W-1:0] widen(input logic [NUM_EVT-1:0] v);
        return {{(REG_W-NUM_EVT){1'b0}}, v};
    endfunction

    // Bus bit index of a register bit counted from the MSB
    function automatic int bus_pos(input int msb_first_bit);
        return REG_W - 1 - msb_first_bit;
    endfunction

endpackage

// File: rtl/usb_evt_idle_det.sv
module usb_evt_idle_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic level,
    output logic changed
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= line_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], line_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign level   = sync_q[STAGES-1];
    assign changed = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/usb_evt_bsy_det.sv
module usb_evt_bsy_det (
    input  logic clk,
    input  logic rst,
    input  logic char_valid,
    input  logic buf_avail,
    output logic busy_set
);
    // High while inside a run of characters that found no buffer
    logic in_run_q;

    always_ff @(posedge clk) begin
        if (rst)             in_run_q <= 1'b0;
        else if (char_valid) in_run_q <= ~buf_avail;
    end

    assign busy_set = char_valid & ~buf_avail & ~in_run_q;

endmodule

// File: rtl/usb_evt_latch.sv
module usb_evt_latch #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)           q[i] <= 1'b0;
                else if (set_i[i]) q[i] <= 1'b1;   // a new event beats a clear
                else if (clr_i[i]) q[i] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/usb_evt_irq_gen.sv
module usb_evt_irq_gen #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mask_we,
    input  logic [W-1:0] mask_d,
    input  logic [W-1:0] evt_q,
    output logic [W-1:0] mask_q,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_d;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(evt_q & mask_q);
    end

endmodule

// File: rtl/usb_evt_irq_ctl.sv
module usb_evt_irq_ctl
    import usb_evt_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] EVT_OFS     = 12'hA10,
    parameter logic [ADDR_W-1:0] MASK_OFS    = 12'hA14,
    parameter logic [ADDR_W-1:0] STAT_OFS    = 12'hA18,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              line_idle,
    input  logic              usb_rst_det,
    input  logic [NUM_EP-1:0] tx_err_ep,
    input  logic              sof_rcvd,
    input  logic              rx_char_valid,
    input  logic              rx_buf_avail,
    input  logic              tx_last_fifo,
    input  logic              tx_last_wire,
    input  logic              tx_last_flag,
    input  logic              rx_buf_closed,
    output logic              irq
);
    evt_vec_t           set_s;
    logic [NUM_EVT-1:0] set_vec;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] evt_q;
    logic [NUM_EVT-1:0] mask_q;
    logic               idle_lvl;
    logic               idle_chg;
    logic               bsy_set;
    logic               txb_set;
    logic               mask_we;
    reg_sel_t           sel;

    usb_evt_idle_det #(.STAGES(SYNC_STAGES)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_idle),
        .level   (idle_lvl),
        .changed (idle_chg)
    );

    usb_evt_bsy_det u_bsy (
        .clk        (clk),
        .rst        (rst),
        .char_valid (rx_char_valid),
        .buf_avail  (rx_buf_avail),
        .busy_set   (bsy_set)
    );

    // The buffer's last flag chooses which completion point counts
    assign txb_set = tx_last_flag ? tx_last_wire : tx_last_fifo;

    always_comb begin
        set_s.usb_rst  = usb_rst_det;
        set_s.idle_chg = idle_chg;
        set_s.tx_err   = tx_err_ep;
        set_s.sof      = sof_rcvd;
        set_s.busy     = bsy_set;
        set_s.tx_done  = txb_set;
        set_s.rx_done  = rx_buf_closed;
        set_vec        = set_s;
    end

    always_comb begin
        if (bus_addr == EVT_OFS)       sel = SEL_EVT;
        else if (bus_addr == MASK_OFS) sel = SEL_MASK;
        else if (bus_addr == STAT_OFS) sel = SEL_STAT;
        else                           sel = SEL_NONE;
    end

    assign clr_vec = (bus_wr && sel == SEL_EVT) ? bus_wdata[NUM_EVT-1:0] : '0;
    assign mask_we = bus_wr && (sel == SEL_MASK);

    usb_evt_latch #(.W(NUM_EVT)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q     (evt_q)
    );

    usb_evt_irq_gen #(.W(NUM_EVT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_we (mask_we),
        .mask_d  (bus_wdata[NUM_EVT-1:0]),
        .evt_q   (evt_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || !bus_rd) begin
            bus_rdata <= '0;
        end else begin
            case (sel)
                SEL_EVT:  bus_rdata <= widen(evt_q);
                SEL_MASK: bus_rdata <= widen(mask_q);
                SEL_STAT: bus_rdata <= {{(REG_W-1){1'b0}}, idle_lvl};
                default:  bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/usb_evt_irq_ctl_chk.sv
module usb_evt_irq_ctl_chk
    import usb_evt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [REG_W-1:0]   bus_rdata,
    input logic [REG_W-1:0]   bus_wdata,
    input logic               irq,
    input logic [NUM_EVT-1:0] set_vec,
    input logic [NUM_EVT-1:0] clr_vec,
    input logic [NUM_EVT-1:0] evt_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic               mask_we,
    input logic               bsy_set
);
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (evt_q == '0 && mask_q == '0 && !irq));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[REG_W-1:NUM_EVT] == '0);

    assert_set_sticks_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

    assert_untouched_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((evt_q ^ $past(evt_q)) & ~$past(set_vec | clr_vec)) == '0));

    assert_clear_works_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((evt_q & $past(clr_vec & ~set_vec)) == '0));

    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & clr_vec)) |=> ((evt_q & $past(set_vec & clr_vec)) != '0));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(bus_wdata[NUM_EVT-1:0])));

    assert_irq_tracks_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (irq == $past(|(evt_q & mask_q))));

    assert_busy_single_R9: assert property (@(posedge clk) disable iff (rst)
        bsy_set |=> !bsy_set);

endmodule

bind usb_evt_irq_ctl usb_evt_irq_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rdata (bus_rdata),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .mask_we   (mask_we),
    .bsy_set   (bsy_set)
);

// File: tb/usb_evt_irq_ctl_test.sv
module usb_evt_irq_ctl_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [11:0] A_EVT  = 12'hA10;
    localparam logic [11:0] A_MASK = 12'hA14;
    localparam logic [11:0] A_STAT = 12'hA18;
    localparam logic [15:0] LIVE   = 16'h03FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        line_idle = 1'b0;
    logic        usb_rst_det = 1'b0;
    logic [3:0]  tx_err_ep = '0;
    logic        sof_rcvd = 1'b0;
    logic        rx_char_valid = 1'b0;
    logic        rx_buf_avail = 1'b1;
    logic        tx_last_fifo = 1'b0;
    logic        tx_last_wire = 1'b0;
    logic        tx_last_flag = 1'b0;
    logic        rx_buf_closed = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    usb_evt_irq_ctl uut (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .line_idle     (line_idle),
        .usb_rst_det   (usb_rst_det),
        .tx_err_ep     (tx_err_ep),
        .sof_rcvd      (sof_rcvd),
        .rx_char_valid (rx_char_valid),
        .rx_buf_avail  (rx_buf_avail),
        .tx_last_fifo  (tx_last_fifo),
        .tx_last_wire  (tx_last_wire),
        .tx_last_flag  (tx_last_flag),
        .rx_buf_closed (rx_buf_closed),
        .irq           (irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model state, built from the requirements
    logic [15:0] m_evt  = '0;
    logic [15:0] m_mask = '0;
    logic        m_irq  = 1'b0;
    logic        m_s0   = 1'b0;
    logic        m_s1   = 1'b0;
    logic        m_prev = 1'b0;
    logic        m_run  = 1'b0;
    string       cur_tag = "R11";

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] read_value(input logic [11:0] a);
        if (a == A_EVT)       return m_evt;
        else if (a == A_MASK) return m_mask;
        else if (a == A_STAT) return {15'b0, m_s1};
        else                  return 16'h0000;
    endfunction

    task automatic tick();
        logic [15:0] setv, clrv, rdv;
        logic        chg, bsy, txb, was_rd;
        @(posedge clk);
        chg  = m_s1 ^ m_prev;
        bsy  = rx_char_valid && !rx_buf_avail && !m_run;
        txb  = tx_last_flag ? tx_last_wire : tx_last_fifo;
        setv = {6'b0, usb_rst_det, chg, tx_err_ep, sof_rcvd, bsy, txb, rx_buf_closed};
        clrv = (bus_wr && bus_addr == A_EVT) ? (bus_wdata & LIVE) : 16'h0000;
        rdv  = bus_rd ? read_value(bus_addr) : 16'h0000;
        was_rd = bus_rd;
        m_irq  = |(m_evt & m_mask);
        m_evt  = (m_evt & ~clrv) | setv;
        if (bus_wr && bus_addr == A_MASK) m_mask = bus_wdata & LIVE;
        if (rx_char_valid) m_run = !rx_buf_avail;
        m_prev = m_s1;
        m_s1   = m_s0;
        m_s0   = line_idle;
        @(negedge clk);
        check("R7 irq", {15'b0, irq}, {15'b0, m_irq});
        if (was_rd) check(cur_tag, bus_rdata, rdv);
        bus_wr = 1'b0; bus_rd = 1'b0;
        usb_rst_det = 1'b0; tx_err_ep = '0; sof_rcvd = 1'b0;
        rx_char_valid = 1'b0; tx_last_fifo = 1'b0; tx_last_wire = 1'b0;
        rx_buf_closed = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cur_tag = tag; bus_addr = a; bus_rd = 1'b1;
        tick();
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1F2E3D4C);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq after reset", {15'b0, irq}, 16'h0000);
        rd(A_EVT,  "R1 event reset");
        rd(A_MASK, "R1 mask reset");
        rd(A_STAT, "R8 status reset");

        // R2 R6: mask layout, reserved bits dropped
        wr(A_MASK, 16'hFFFF);
        rd(A_MASK, "R6 mask readback");
        check("R2 R6 mask reserved ignored", bus_rdata, 16'h03FF);
        wr(A_EVT, 16'hFC00);
        rd(A_EVT, "R2 reserved write");
        check("R2 reserved event read", bus_rdata, 16'h0000);

        // R3: sticky latch
        sof_rcvd = 1'b1; tick();
        rd(A_EVT, "R3 sof latched");
        check("R3 sof bit", bus_rdata, 16'h0008);
        idle_ticks(3);
        rd(A_EVT, "R3 sticky");
        check("R3 sof held", bus_rdata, 16'h0008);

        // R2: bit positions
        usb_rst_det = 1'b1; tx_err_ep = 4'hF; rx_buf_closed = 1'b1; tick();
        rd(A_EVT, "R2 layout");
        check("R2 layout literal", bus_rdata, 16'h02F9);

        // R4: write-one-to-clear, zeros keep
        wr(A_EVT, 16'h00A1);
        rd(A_EVT, "R4 partial clear");
        check("R4 partial clear literal", bus_rdata, 16'h0258);

        // R7: held until every enabled bit is clear
        wr(A_MASK, 16'h0008);
        wr(A_EVT, 16'h0250);
        check("R7 held while enabled bit set", {15'b0, irq}, 16'h0001);
        wr(A_EVT, 16'h0008);
        tick();
        check("R7 drops after last clear", {15'b0, irq}, 16'h0000);
        rx_buf_closed = 1'b1; tick();
        tick();
        check("R7 masked event no irq", {15'b0, irq}, 16'h0000);
        rd(A_EVT, "R7 masked event latched");
        check("R7 masked bit visible", bus_rdata, 16'h0001);
        wr(A_EVT, 16'h0001);

        // R5: set beats clear in the same cycle
        sof_rcvd = 1'b1; bus_addr = A_EVT; bus_wdata = 16'h0008; bus_wr = 1'b1;
        tick();
        rd(A_EVT, "R5 collision");
        check("R5 set wins", bus_rdata, 16'h0008);
        wr(A_EVT, 16'h0008);

        // R8: idle change both directions
        line_idle = 1'b1;
        idle_ticks(4);
        rd(A_EVT, "R8 rise");
        check("R8 rise literal", bus_rdata, 16'h0100);
        rd(A_STAT, "R8 status");
        check("R8 status literal", bus_rdata, 16'h0001);
        wr(A_EVT, 16'h0100);
        line_idle = 1'b0;
        idle_ticks(4);
        rd(A_EVT, "R8 fall");
        check("R8 fall literal", bus_rdata, 16'h0100);
        wr(A_EVT, 16'h0100);

        // R9: busy once per run
        rx_buf_avail = 1'b0;
        for (int k = 0; k < 3; k++) begin
            rx_char_valid = 1'b1; tick();
        end
        rd(A_EVT, "R9 first");
        check("R9 first literal", bus_rdata, 16'h0004);
        wr(A_EVT, 16'h0004);
        rx_char_valid = 1'b1; tick();
        rd(A_EVT, "R9 no repeat");
        check("R9 no repeat literal", bus_rdata, 16'h0000);
        rx_buf_avail = 1'b1; rx_char_valid = 1'b1; tick();
        rx_buf_avail = 1'b0; rx_char_valid = 1'b1; tick();
        rd(A_EVT, "R9 new run");
        check("R9 new run literal", bus_rdata, 16'h0004);
        wr(A_EVT, 16'h0004);
        rx_buf_avail = 1'b1;

        // R10: transmit completion point
        tx_last_flag = 1'b0; tx_last_wire = 1'b1; tick();
        rd(A_EVT, "R10 wire ignored");
        check("R10 wire ignored literal", bus_rdata, 16'h0000);
        tx_last_fifo = 1'b1; tick();
        rd(A_EVT, "R10 fifo point");
        check("R10 fifo literal", bus_rdata, 16'h0002);
        wr(A_EVT, 16'h0002);
        tx_last_flag = 1'b1; tx_last_fifo = 1'b1; tick();
        rd(A_EVT, "R10 fifo ignored");
        check("R10 fifo ignored literal", bus_rdata, 16'h0000);
        tx_last_wire = 1'b1; tick();
        rd(A_EVT, "R10 wire point");
        check("R10 wire literal", bus_rdata, 16'h0002);

        // R11: unmapped and idle bus
        rd(12'h000, "R11 unmapped");
        check("R11 unmapped literal", bus_rdata, 16'h0000);
        tick();
        check("R11 no read", bus_rdata, 16'h0000);

        // Random mix
        for (int it = 0; it < 4000; it++) begin
            int unsigned op;
            usb_rst_det   = ($urandom % 16) == 0;
            tx_err_ep     = 4'($urandom) & 4'($urandom) & 4'($urandom);
            sof_rcvd      = ($urandom % 8) == 0;
            rx_char_valid = ($urandom % 4) == 0;
            rx_buf_avail  = ($urandom % 2) == 0;
            tx_last_fifo  = ($urandom % 8) == 0;
            tx_last_wire  = ($urandom % 8) == 0;
            tx_last_flag  = ($urandom % 2) == 0;
            rx_buf_closed = ($urandom % 8) == 0;
            if (($urandom % 32) == 0) line_idle = ~line_idle;
            op = $urandom % 8;
            cur_tag = "R3 R4 R5 random readback";
            case (op)
                0: begin bus_addr = A_EVT;  bus_wdata = 16'($urandom); bus_wr = 1'b1; end
                1: begin bus_addr = A_MASK; bus_wdata = 16'($urandom); bus_wr = 1'b1; end
                2: begin bus_addr = A_EVT;  bus_rd = 1'b1; end
                3: begin bus_addr = A_MASK; bus_rd = 1'b1; end
                4: begin bus_addr = A_STAT; bus_rd = 1'b1; end
                default: ;
            endcase
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule